// File: doc/BRIEF.md
# Hopping Phase-Increment Bank with Accumulator

This block drives a phase accumulator from a small bank of phase-increment registers that software loads at run time. A write strobe with an address and a data word stores one increment. A band-select input picks which stored increment feeds the accumulator, and that choice can change on any clock. The accumulated phase goes out to a downstream waveform table, which is not part of this block.

The accumulator is never cleared when the band changes. Each hop only changes the step size, so the carrier phase stays continuous across frequency changes. A clock enable gates accumulation. The bank and the band select keep updating while the enable is low. Everything clears on an asynchronous active-low reset.

Top module: `fhop_nco_front`

## Requirements
- R1: After reset, phase_o is 0 and every bank entry is 0, so with the enable high the phase stays 0 for every in-range band until an entry is loaded.
- R2: A write with wr_en_i high and wr_addr_i below NUM_BANDS stores wr_data_i in that entry at the clock edge. If that entry is selected, the accumulator steps by the new value starting at the following edge.
- R3: A write whose wr_addr_i is NUM_BANDS or above changes no entry.
- R4: band_sel_i is registered at each edge. The accumulator steps by the newly selected entry starting at the next edge after the one that registered it.
- R5: A registered band_sel_i of NUM_BANDS or above selects an increment of zero, so phase_o holds even with the enable high.
- R6: With acc_en_i high, phase_o advances at each edge by the active increment, modulo 2^PHASE_W.
- R7: With acc_en_i low, phase_o holds its value. Writes and band selection still take effect.
- R8: A band change never clears or reloads the accumulator. The phase after a hop continues from the phase before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for an increment entry, active high |
| wr_addr_i | input | 4 | Entry index for the write |
| wr_data_i | input | PHASE_W | Increment value to store |
| band_sel_i | input | 4 | Index of the entry that drives the accumulator |
| acc_en_i | input | 1 | Accumulation enable, active high |
| phase_o | output | PHASE_W | Accumulated phase |

## Verification
The bench builds the block with PHASE_W = 16 and NUM_BANDS = 12. The narrow phase word makes accumulator wrap-around happen within a few steps. The reduced depth leaves addresses 12 to 15 as legal port values that fall outside the bank, so both ignored writes and zero-increment selects can be driven. A model of the bank, the registered select and the accumulator is stepped edge by edge and compared with phase_o after every cycle.

// File: rtl/fhop_pkg.sv
package fhop_pkg;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned MAX_BANDS = 1 << IDX_W;
endpackage

// File: rtl/fhop_inc_bank.sv
module fhop_inc_bank
  import fhop_pkg::*;
#(
  parameter int unsigned PHASE_W   = 32,
  parameter int unsigned NUM_BANDS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [PHASE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]   sel_i,
  output logic [PHASE_W-1:0] inc_o
);
  logic [NUM_BANDS-1:0][PHASE_W-1:0] ent_q;
  logic [IDX_W-1:0]                  sel_q;
  logic                              wr_hit;

  assign wr_hit = wr_en_i && (32'(wr_addr_i) < NUM_BANDS);

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    ent_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == IDX_W'(g))     ent_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_i;
  end

  // out-of-range select yields zero step
  always_comb begin
    inc_o = '0;
    for (int i = 0; i < NUM_BANDS; i++)
      if (sel_q == IDX_W'(i)) inc_o = ent_q[i];
  end

  assert_oob_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit) |=> $stable(ent_q));

  assert_write_stores_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> ent_q[$past(wr_addr_i)] == $past(wr_data_i));

  assert_no_write_no_change_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ent_q));
endmodule

// File: rtl/fhop_phase_acc.sv
module fhop_phase_acc #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] inc_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + inc_i;
  end

  assign phase_o = phase_q;

  assert_hold_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_q));
endmodule

// File: rtl/fhop_nco_front.sv
module fhop_nco_front
  import fhop_pkg::*;
#(
  parameter int unsigned PHASE_W   = 32,
  parameter int unsigned NUM_BANDS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [3:0]         wr_addr_i,
  input  logic [PHASE_W-1:0] wr_data_i,
  input  logic [3:0]         band_sel_i,
  input  logic               acc_en_i,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int unsigned DEPTH = (NUM_BANDS < 1) ? 1 :
                                  (NUM_BANDS > MAX_BANDS) ? MAX_BANDS : NUM_BANDS;

  logic [PHASE_W-1:0] inc_act;

  fhop_inc_bank #(.PHASE_W(PHASE_W), .NUM_BANDS(DEPTH)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sel_i     (band_sel_i),
    .inc_o     (inc_act)
  );

  fhop_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (acc_en_i),
    .inc_i   (inc_act),
    .phase_o (phase_o)
  );

  assert_oob_select_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(band_sel_i) >= DEPTH) |=> inc_act == '0);

  assert_step_continuous_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_i |=> phase_o == PHASE_W'($past(phase_o) + $past(inc_act)));
endmodule

// File: tb/fhop_nco_front_bench.sv
module fhop_nco_front_bench;
  localparam int W = 16;
  localparam int N = 12;
  localparam int NV = 22;
  localparam real HALF = 2.0; // 250 MHz

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [3:0]    sel = '0;
  logic          en = 1'b0;
  logic [W-1:0]  phase;

  always #(HALF) clk = ~clk;

  fhop_nco_front #(.PHASE_W(W), .NUM_BANDS(N)) u_fhop_nco_front (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(addr),
    .wr_data_i(wdata), .band_sel_i(sel), .acc_en_i(en), .phase_o(phase)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_bank [16];
  logic [3:0]   m_sel;
  logic [W-1:0] m_phase;

  // {en, we, addr, sel, data}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1,1'b1,4'd0, 4'd0, 16'h0100},
    {1'b1,1'b1,4'd1, 4'd0, 16'h0040},
    {1'b1,1'b1,4'd11,4'd0, 16'hF000},
    {1'b1,1'b0,4'd0, 4'd1, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd1, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd11,16'h0000},
    {1'b1,1'b0,4'd0, 4'd11,16'h0000},
    {1'b1,1'b0,4'd0, 4'd11,16'h0000},
    {1'b1,1'b1,4'd12,4'd0, 16'h7777},
    {1'b1,1'b1,4'd15,4'd0, 16'h1234},
    {1'b1,1'b0,4'd0, 4'd0, 16'h0000},
    {1'b1,1'b1,4'd0, 4'd0, 16'h0003},
    {1'b1,1'b0,4'd0, 4'd0, 16'h0000},
    {1'b0,1'b1,4'd5, 4'd5, 16'h0500},
    {1'b0,1'b0,4'd0, 4'd5, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd5, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd13,16'h0000},
    {1'b1,1'b0,4'd0, 4'd13,16'h0000},
    {1'b1,1'b1,4'd5, 4'd5, 16'h0001},
    {1'b1,1'b0,4'd0, 4'd5, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd1, 16'h0000},
    {1'b1,1'b0,4'd0, 4'd1, 16'h0000}
  };

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_bank[i] = '0;
    m_sel = '0;
    m_phase = '0;
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: phase actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, model the edge, compare at next negedge
  task automatic step(string tag, bit e, bit w, logic [3:0] a, logic [3:0] s, logic [W-1:0] d);
    logic [W-1:0] inc;
    we = w; addr = a; sel = s; wdata = d; en = e;
    @(posedge clk);
    inc = (m_sel < 4'(N)) ? m_bank[m_sel] : '0;
    if (e) m_phase = m_phase + inc;
    if (w && a < 4'(N)) m_bank[a] = d;
    m_sel = s;
    @(negedge clk);
    check(tag, phase, m_phase);
  endtask

  initial begin
    #(HALF * 2.0 * 150000.0);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    #(HALF * 3.0);
    @(negedge clk);
    check("R1 reset value", phase, '0);
    rst_n = 1'b1;
    // R1: all entries zero, phase stays 0 across every in-range band
    for (int b = 0; b < N; b++) step("R1 zero bank", 1'b1, 1'b0, 4'd0, 4'(b), '0);

    // table: R2 R3 R4 R5 R6 R7 R8 mixed
    for (int v = 0; v < NV; v++)
      step("R2/R3/R4/R5/R6/R7 vector", VEC[v][25], VEC[v][24], VEC[v][23:20],
           VEC[v][19:16], VEC[v][15:0]);

    // R3: entries 0..11 unchanged after out-of-range writes; probe each band
    step("R3 oob write", 1'b0, 1'b1, 4'd14, 4'd0, 16'hAAAA);
    for (int b = 0; b < N; b++) begin
      step("R3 band select", 1'b0, 1'b0, 4'd0, 4'(b), '0);
      step("R3 band probe",  1'b1, 1'b0, 4'd0, 4'(b), '0);
    end

    // R6: wrap with large step
    step("R6 load", 1'b0, 1'b1, 4'd2, 4'd2, 16'hC001);
    for (int k = 0; k < 4; k++) step("R6 wrap", 1'b1, 1'b0, 4'd0, 4'd2, '0);

    // R8: hop from band 2 to band 1 keeps phase running
    step("R8 hop", 1'b1, 1'b0, 4'd0, 4'd1, '0);
    step("R8 after hop", 1'b1, 1'b0, 4'd0, 4'd1, '0);

    // R5: out-of-range select holds phase with enable high
    step("R5 select oob", 1'b1, 1'b0, 4'd0, 4'd15, '0);
    step("R5 hold", 1'b1, 1'b0, 4'd0, 4'd15, '0);

    // R7: disabled, write and select still land
    step("R7 idle write", 1'b0, 1'b1, 4'd7, 4'd7, 16'h0011);
    step("R7 idle hold", 1'b0, 1'b0, 4'd0, 4'd7, '0);
    step("R7 resume", 1'b1, 1'b0, 4'd0, 4'd7, '0);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    #(HALF / 2.0);
    rst_n = 1'b0;
    #(HALF / 4.0);
    check("R1 async reset", phase, '0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 bank cleared", 1'b1, 1'b0, 4'd0, 4'd7, '0);
    step("R1 bank cleared", 1'b1, 1'b0, 4'd0, 4'd7, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule